// File: doc/BRIEF.md
# Serial Flash Bulk-Read Streamer with Image Checksum

This block pulls a long run of data out of a serial flash that has already been given its read command and start address. It drives the serial clock straight from the system clock, so the clock level flips on every system clock while data moves and one data bit takes two system clocks. The data-out line of the flash is sampled once per bit, while the serial clock is high. The bits are gathered into bytes with the most significant bit first, then into 32-bit words, and each word is written to a local RAM port at addresses that count up from zero.

A start pulse loads a word count. The block splits the transfer into blocks of at most `BLK_MAX` words and takes each block size off the remaining count before that block runs. It stops when the count reaches zero. One planning cycle separates consecutive blocks. Every stored word is added to a supplied value that should be the negated sum of the image. A zero total reports pass. Any other total reports fail: the block releases its chip-select, data-to-flash and clock drivers and stays halted until reset.

Top module: `flash_bulk_reader`

## Requirements
- R1: While a block runs, `sck` changes level on every system clock. It is never high for two clocks in a row, and it is low whenever `sck_oe` is low.
- R2: A block of B words produces exactly 64·B level changes on `sck`, which is 32·B rising edges. A run of N words therefore gives 32·N rising edges in total.
- R3: The level of `miso` is captured at each clock where `sck` is high. Every group of 8 captured bits forms a byte with the first bit in bit 7. Four bytes form a word with the first byte in bits [7:0]. Each word is written with a one-cycle `mem_we` pulse, and `mem_addr` starts at 0 for every run and increases by 1 per word.
- R4: No block is larger than `BLK_MAX` words. The blocks are sized min(remaining, `BLK_MAX`), and each block is preceded by one planning cycle. Counting from the clock edge that samples `start`, `done` rises after nb + 64·N + 2 edges, where nb = ceil(N / `BLK_MAX`).
- R5: If `neg_sum` plus the sum of all N words is 0 modulo 2^32, the run ends with `done`=1, `pass`=1 and `fail`=0.
- R6: If that total is not 0, the run ends with `done`=1 and `fail`=1, and `sck_oe` and `ctl_oe` both go low. Later `start` pulses are then ignored, and only reset clears this state.
- R7: A word count of 0 causes no `sck` edges and no writes. `done` rises two edges after `start`, and the result depends only on whether `neg_sum` is zero.
- R8: `busy` is high from the edge after `start` until the result is reported. `done` and the result stay held until the next accepted `start`. A `start` that arrives while `busy` is high has no effect.
- R9: `sck_oe` is high only while blocks are being planned or transferred, and it is low once the run ends. `ctl_oe` is high at all times except in the failed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run |
| word_count | input | CNT_W | Number of 32-bit words to read |
| neg_sum | input | 32 | Negated sum of the expected image |
| miso | input | 1 | Data line coming from the flash |
| sck | output | 1 | Serial clock to the flash |
| sck_oe | output | 1 | Drive enable for the serial clock pad |
| ctl_oe | output | 1 | Drive enable for the chip-select and data-to-flash pads |
| mem_we | output | 1 | Word write strobe |
| mem_addr | output | ADDR_W | Word write address |
| mem_wdata | output | 32 | Word write data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The run has finished (held) |
| pass | output | 1 | The checksum total was zero |
| fail | output | 1 | The checksum total was nonzero; the block is halted |

## Verification
The bench builds the block with `BLK_MAX`=3, `CNT_W`=8 and `ADDR_W`=6. With these values, runs of 3, 5 and 7 words cover three cases: a single full block, a full block followed by a partial one, and several full blocks followed by a one-word tail. Each case is checked for SCK edge counts, write order and completion latency. The small counter widths also keep the zero-count case, the failed halt and the start pulse that arrives mid-run inside a short run.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
   localparam int BYTE_W  = 8;
   localparam int LANES   = 4;
   localparam int WORD_W  = BYTE_W * LANES;
   localparam int BIT_SH  = $clog2(WORD_W);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PLAN,
      ST_XFER,
      ST_CHECK,
      ST_DONE,
      ST_HALT
   } fbr_state_t;
endpackage

// File: rtl/fbr_chunker.sv
module fbr_chunker #(
   parameter int CNT_W   = 16,
   parameter int BLK_MAX = 2047,
   localparam int BLK_W  = $clog2(BLK_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic             take,
   output logic             rem_zero,
   output logic [BLK_W-1:0] blk_words
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BLK_MAX);

   logic [CNT_W-1:0] remaining;
   logic [CNT_W-1:0] blk_full;

   always_comb begin
      blk_full  = (remaining > LIMIT) ? LIMIT : remaining;
      blk_words = BLK_W'(blk_full);
      rem_zero  = (remaining == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remaining <= '0;
      end else if (load) begin
         remaining <= load_cnt;
      end else if (take) begin
         remaining <= remaining - blk_full;
      end
   end
endmodule

// File: rtl/fbr_sck_gen.sv
module fbr_sck_gen #(
   parameter int BITS_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic [BITS_W-1:0] arm_bits,
   output logic              sck,
   output logic              sample,
   output logic              last
);
   logic              active;
   logic [BITS_W-1:0] bits_left;

   always_comb begin
      sample = active && sck;
      last   = sample && (bits_left == BITS_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         bits_left <= '0;
         sck       <= 1'b0;
      end else if (arm) begin
         active    <= 1'b1;
         bits_left <= arm_bits;
         sck       <= 1'b0;
      end else if (active) begin
         sck <= ~sck;
         if (sck) begin
            bits_left <= bits_left - BITS_W'(1);
            if (bits_left == BITS_W'(1)) begin
               active <= 1'b0;
            end
         end
      end else begin
         sck <= 1'b0;
      end
   end
endmodule

// File: rtl/fbr_deser.sv
module fbr_deser
   import fbr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              sample,
   input  logic              din,
   output logic              word_valid,
   output logic [WORD_W-1:0] word
);
   localparam int LANE_W = $clog2(LANES);
   localparam int CNT_W  = $clog2(BYTE_W);

   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-2:0] shreg;
   logic [LANE_W-1:0] lane;
   logic [BYTE_W-1:0] new_byte;
   logic              byte_done;
   logic [BYTE_W-1:0] hold [LANES-1];

   always_comb begin
      new_byte   = {shreg, din};
      byte_done  = sample && (bit_cnt == CNT_W'(BYTE_W - 1));
      word_valid = byte_done && (lane == LANE_W'(LANES - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shreg   <= '0;
         lane    <= '0;
      end else if (clear) begin
         bit_cnt <= '0;
         shreg   <= '0;
         lane    <= '0;
      end else if (sample) begin
         bit_cnt <= bit_cnt + CNT_W'(1);
         shreg   <= new_byte[BYTE_W-2:0];
         if (byte_done) begin
            lane <= lane + LANE_W'(1);
         end
      end
   end

   for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold[g] <= '0;
         end else if (byte_done && lane == LANE_W'(g)) begin
            hold[g] <= new_byte;
         end
      end
      assign word[g*BYTE_W +: BYTE_W] = hold[g];
   end
   assign word[WORD_W-1 -: BYTE_W] = new_byte;
endmodule

// File: rtl/flash_bulk_reader.sv
module flash_bulk_reader
   import fbr_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int ADDR_W  = 16,
   parameter int BLK_MAX = 2047
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  word_count,
   input  logic [31:0]       neg_sum,
   input  logic              miso,
   output logic              sck,
   output logic              sck_oe,
   output logic              ctl_oe,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic              fail
);
   localparam int BLK_W  = $clog2(BLK_MAX + 1);
   localparam int BITS_W = BLK_W + BIT_SH;

   if (BLK_MAX < 1) begin : g_bad_blk
      $error("BLK_MAX must be at least 1");
   end
   if (BLK_MAX >= (1 << CNT_W)) begin : g_bad_cnt
      $error("BLK_MAX must fit in CNT_W bits");
   end
   if (WORD_W != 32) begin : g_bad_word
      $error("word width must be 32");
   end

   fbr_state_t        state;
   logic              rem_zero;
   logic [BLK_W-1:0]  blk_words;
   logic              plan_go;
   logic              sck_sample;
   logic              sck_last;
   logic              word_valid;
   logic [31:0]       word;
   logic [ADDR_W-1:0] wr_ptr;
   logic [31:0]       acc;
   logic              accept;

   always_comb begin
      accept  = start && (state == ST_IDLE || state == ST_DONE);
      plan_go = (state == ST_PLAN) && !rem_zero;
      busy    = (state == ST_PLAN) || (state == ST_XFER) || (state == ST_CHECK);
      done    = (state == ST_DONE) || (state == ST_HALT);
      pass    = (state == ST_DONE);
      fail    = (state == ST_HALT);
      sck_oe  = (state == ST_PLAN) || (state == ST_XFER);
      ctl_oe  = (state != ST_HALT);
   end

   fbr_chunker #(.CNT_W(CNT_W), .BLK_MAX(BLK_MAX)) u_chunk (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_cnt  (word_count),
      .take      (plan_go),
      .rem_zero  (rem_zero),
      .blk_words (blk_words)
   );

   fbr_sck_gen #(.BITS_W(BITS_W)) u_sck (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (plan_go),
      .arm_bits ({blk_words, {BIT_SH{1'b0}}}),
      .sck      (sck),
      .sample   (sck_sample),
      .last     (sck_last)
   );

   fbr_deser u_deser (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (accept),
      .sample     (sck_sample),
      .din        (miso),
      .word_valid (word_valid),
      .word       (word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else begin
         case (state)
            ST_IDLE, ST_DONE: if (accept) state <= ST_PLAN;
            ST_PLAN:          state <= rem_zero ? ST_CHECK : ST_XFER;
            ST_XFER:          if (sck_last) state <= ST_PLAN;
            ST_CHECK:         state <= (acc == 32'd0) ? ST_DONE : ST_HALT;
            ST_HALT:          state <= ST_HALT;
            default:          state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         wr_ptr    <= '0;
         acc       <= '0;
      end else begin
         mem_we <= word_valid;
         if (accept) begin
            wr_ptr <= '0;
            acc    <= neg_sum;
         end else if (word_valid) begin
            mem_addr  <= wr_ptr;
            mem_wdata <= word;
            wr_ptr    <= wr_ptr + ADDR_W'(1);
            acc       <= acc + word;
         end
      end
   end
endmodule

// File: rtl/fbr_checker.sv
module fbr_checker (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic sck,
   input logic sck_oe,
   input logic ctl_oe,
   input logic mem_we,
   input logic busy,
   input logic done,
   input logic pass,
   input logic fail
);
   // R1
   sck_one_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sck |=> !sck);
   // R1
   sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sck_oe |-> !sck);
   // R3
   write_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);
   // R5
   result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass && fail));
   // R6
   halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> (!ctl_oe && !sck_oe));
   // R6
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail |=> fail);
   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R9
   oe_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sck_oe |-> busy);
endmodule

bind flash_bulk_reader fbr_checker u_fbr_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .sck    (sck),
   .sck_oe (sck_oe),
   .ctl_oe (ctl_oe),
   .mem_we (mem_we),
   .busy   (busy),
   .done   (done),
   .pass   (pass),
   .fail   (fail)
);

// File: tb/sim_flash_bulk_reader.sv
module sim_flash_bulk_reader;
   localparam int CNT_W   = 8;
   localparam int ADDR_W  = 6;
   localparam int BLK_MAX = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [CNT_W-1:0]  word_count = '0;
   logic [31:0]       neg_sum = '0;
   logic              miso = 1'b0;
   logic              sck, sck_oe, ctl_oe, mem_we, busy, done, pass, fail;
   logic [ADDR_W-1:0] mem_addr;
   logic [31:0]       mem_wdata;

   int checks = 0;
   int errors = 0;
   int rise_cnt = 0;
   int wr_idx = 0;
   int inv_err = 0;
   bit finished = 0;
   logic sck_d = 1'b0;
   logic [7:0] img [0:63];
   logic [31:0] exp_q [$];

   always #10 clk = ~clk;

   flash_bulk_reader #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BLK_MAX(BLK_MAX)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .word_count(word_count),
      .neg_sum(neg_sum), .miso(miso), .sck(sck), .sck_oe(sck_oe),
      .ctl_oe(ctl_oe), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .busy(busy), .done(done), .pass(pass),
      .fail(fail));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_sim();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // flash model and per-clock reference comparison
   always @(negedge clk) begin
      if (sck && sck_d) inv_err++;            // R1 high twice
      if (sck && !sck_oe) inv_err++;          // R1 idle low
      if (sck && !sck_d) begin
         miso = img[(rise_cnt / 8) % 64][7 - (rise_cnt % 8)];
         rise_cnt++;
      end
      sck_d = sck;
      if (mem_we) begin
         if (exp_q.size() == 0) begin
            chk("R3 unexpected write", 64'(mem_wdata), 64'hdead);
         end else begin
            chk("R3 write addr", 64'(mem_addr), 64'(wr_idx));
            chk("R3 write data", 64'(mem_wdata), 64'(exp_q.pop_front()));
         end
         wr_idx++;
      end
   end

   task automatic run(input int n, input int seed, input bit bad, input bit poke);
      logic [31:0] sum = 0;
      int nb = (n + BLK_MAX - 1) / BLK_MAX;
      int t_exp = nb + 64 * n + 2;
      int cyc = 0;
      for (int i = 0; i < 64; i++) img[i] = 8'((i * 37 + seed * 11 + 5) & 255);
      exp_q.delete();
      for (int w = 0; w < n; w++) begin
         logic [31:0] v = {img[4*w+3], img[4*w+2], img[4*w+1], img[4*w]};
         exp_q.push_back(v);
         sum += v;
      end
      rise_cnt = 0; wr_idx = 0; inv_err = 0;
      @(negedge clk);
      word_count = CNT_W'(n);
      neg_sum = -sum + (bad ? 32'd1 : 32'd0);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk("R8 busy after start", 64'(busy), 64'(1));
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         if (poke && cyc == 7) start = 1'b1;
         else start = 1'b0;
      end
      start = 1'b0;
      chk("R4 latency", 64'(cyc), 64'(t_exp));
      chk("R2 sck rises", 64'(rise_cnt), 64'(32 * n));
      chk("R3 words written", 64'(wr_idx), 64'(n));
      chk("R1 sck shape", 64'(inv_err), 64'(0));
      chk(bad ? "R6 fail flag" : "R5 pass flag", 64'({pass, fail}), bad ? 64'b01 : 64'b10);
      chk("R9 sck_oe low", 64'(sck_oe), 64'(0));
      chk(bad ? "R6 ctl_oe released" : "R9 ctl_oe held", 64'(ctl_oe), bad ? 64'(0) : 64'(1));
      repeat (5) @(negedge clk);
      chk("R8 done held", 64'({done, busy}), 64'b10);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_sim();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset oe", 64'({sck, sck_oe, ctl_oe}), 64'b001);
      chk("R8 reset status", 64'({busy, done, pass, fail, mem_we}), 64'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run(5, 1, 0, 0);          // R4 full + partial block
      run(3, 2, 0, 0);          // R4 one full block
      run(0, 3, 0, 0);          // R7 zero count, pass
      chk("R7 zero count pass", 64'(pass), 64'(1));
      run(7, 4, 0, 1);          // R8 start ignored while busy
      run(4, 5, 1, 0);          // R6 checksum mismatch
      rise_cnt = 0; wr_idx = 0;
      @(negedge clk);
      word_count = 2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      chk("R6 halted ignores start", 64'({busy, fail, rise_cnt[7:0]}), {54'b0, 2'b01, 8'd0});
      rst_n = 1'b0;
      @(negedge clk);
      chk("R6 reset clears halt", 64'({fail, ctl_oe}), 64'b01);
      rst_n = 1'b1;
      @(negedge clk);
      run(0, 6, 1, 0);          // R7 zero count, nonzero sum fails
      chk("R7 zero count fail", 64'(fail), 64'(1));
      finish_sim();
   end
endmodule